// File: doc/BRIEF.md
# Register-File Context Save/Restore Sequencer

This block moves a whole general-purpose register file to memory and back. Each of the 256 registers holds a 64-bit data word plus a carry flag and an overflow flag. The flags do not travel with the data word. They are packed into eight 64-bit extension words. Each extension word covers one block of 32 consecutive registers and holds two bits per register.

A save streams the 256 data words to memory in register order and collects the flags as it goes. It then waits until memory has acknowledged every data write. Only after that wait does it write the eight extension words.

A restore runs in the opposite order. It first fetches the eight extension words and waits until all of those reads have returned. It then reads the 256 data words back in order. Each returned word is written into the register file together with its two flags, which are taken from the extension word already fetched.

Memory traffic uses one request channel with a valid/ready handshake and a separate in-order response channel. Responses are returned for reads and for writes.

Top module: `ctxsv_seq`

## Requirements
- R1: A save issues write requests at word addresses 0 to 255 in ascending order. The data of the request at address n equals the data word of register n.
- R2: After the data writes, a save writes extension words to addresses 256 to 263 in ascending order. In the extension word at address 256+k, bit 2i holds the carry flag of register 32k+i and bit 2i+1 holds its overflow flag.
- R3: No extension-word write of a save is issued before responses for all 256 data writes have been received.
- R4: A restore issues read requests first to addresses 256 to 263, then to addresses 0 to 255, each group in ascending order. No data read is issued before all eight extension-read responses have arrived.
- R5: When a restore finishes, every register n holds the word read from address n. Its carry flag and overflow flag equal bits 2(n mod 32) and 2(n mod 32)+1 of the extension word read from address 256 + n/32.
- R6: While a request is valid and not ready, valid, write-enable, address and write data stay unchanged into the next cycle.
- R7: A start_save or start_restore pulse that arrives while busy is high has no effect. No extra operation follows the current one.
- R8: done is high for exactly one cycle, in the cycle in which busy falls. At that point no memory transaction is outstanding.
- R9: While reset is applied, busy, done, mem_valid and rf_wr_en are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_save | input | 1 | Pulse: begin a context save when idle |
| start_restore | input | 1 | Pulse: begin a context restore when idle (save wins if both) |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_rd_addr | output | 8 | Register file read index |
| rf_rd_data | input | 64 | Data word of the addressed register |
| rf_rd_carry | input | 1 | Carry flag of the addressed register |
| rf_rd_ovf | input | 1 | Overflow flag of the addressed register |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_wr_addr | output | 8 | Register file write index |
| rf_wr_data | output | 64 | Data word to write |
| rf_wr_carry | output | 1 | Carry flag to write |
| rf_wr_ovf | output | 1 | Overflow flag to write |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | Request is a write (1) or read (0) |
| mem_addr | output | 9 | Word address of the request |
| mem_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | In-order response for one accepted request |
| mem_rdata | input | 64 | Read data of the response |

## Verification
The bench runs saves and restores against a memory model that varies in two ways: when it raises ready (always ready, random stalls, or a periodic two-on/two-off pattern) and how long a response takes (one to four cycles). Always-ready with short latency confirms the plain request order and data. Random stalls test whether held requests stay stable and whether the flag capture stays aligned when acceptance slips. Long latency tests whether the sync waits really cover every outstanding response. The flag patterns used are register-index derived and random, which separates the carry bit position from the overflow bit position in the packing. A restore is always preceded by scrambling the register file, so only correct merging can reproduce the saved image.

// File: rtl/ctxsv_pkg.sv
package ctxsv_pkg;
    localparam int unsigned NREGS = 256;
    localparam int unsigned BLK   = 32;
    localparam int unsigned DW    = 64;
    localparam int unsigned NXR   = NREGS / BLK;
    localparam int unsigned RIW   = $clog2(NREGS);
    localparam int unsigned XIW   = $clog2(NXR);
    localparam int unsigned BIW   = $clog2(BLK);
    localparam int unsigned MAW   = $clog2(NREGS + NXR);
    localparam int unsigned XWW   = 2 * BLK;
    localparam int unsigned CNTW  = MAW + 1;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_SV_DATA,
        PH_SV_SYNC,
        PH_SV_XTRA,
        PH_SV_DRAIN,
        PH_RS_XTRA,
        PH_RS_SYNC,
        PH_RS_DATA,
        PH_RS_DRAIN
    } phase_e;

    typedef struct packed {
        logic           we;
        logic [MAW-1:0] addr;
        logic [DW-1:0]  wdata;
    } mreq_t;

    function automatic logic [XIW-1:0] xreg_of(input logic [RIW-1:0] r);
        return r[RIW-1:BIW];
    endfunction

    function automatic logic [BIW-1:0] slot_of(input logic [RIW-1:0] r);
        return r[BIW-1:0];
    endfunction

    function automatic logic [MAW-1:0] xaddr(input logic [XIW-1:0] k);
        return MAW'(NREGS) + MAW'(k);
    endfunction
endpackage

// File: rtl/ctxsv_xbank.sv
module ctxsv_xbank
    import ctxsv_pkg::*;
#(
    parameter bit SHARED = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cap_en,
    input  logic [RIW-1:0] cap_reg,
    input  logic           cap_c,
    input  logic           cap_v,
    input  logic           ld_en,
    input  logic [XIW-1:0] ld_idx,
    input  logic [XWW-1:0] ld_word,
    input  logic [XIW-1:0] rd_idx,
    output logic [XWW-1:0] rd_word,
    input  logic [RIW-1:0] fl_reg,
    output logic           fl_c,
    output logic           fl_v
);
    if (SHARED) begin : g_shared
        logic [XWW-1:0] bank [NXR];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int unsigned i = 0; i < NXR; i++) bank[i] <= '0;
            end else begin
                if (cap_en)
                    bank[xreg_of(cap_reg)][{slot_of(cap_reg), 1'b0} +: 2] <= {cap_v, cap_c};
                if (ld_en)
                    bank[ld_idx] <= ld_word;
            end
        end

        assign rd_word = bank[rd_idx];
        assign fl_c    = bank[xreg_of(fl_reg)][{slot_of(fl_reg), 1'b0}];
        assign fl_v    = bank[xreg_of(fl_reg)][{slot_of(fl_reg), 1'b1}];
    end else begin : g_split
        logic [XWW-1:0] sv_bank [NXR];
        logic [XWW-1:0] rs_bank [NXR];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int unsigned i = 0; i < NXR; i++) begin
                    sv_bank[i] <= '0;
                    rs_bank[i] <= '0;
                end
            end else begin
                if (cap_en)
                    sv_bank[xreg_of(cap_reg)][{slot_of(cap_reg), 1'b0} +: 2] <= {cap_v, cap_c};
                if (ld_en)
                    rs_bank[ld_idx] <= ld_word;
            end
        end

        assign rd_word = sv_bank[rd_idx];
        assign fl_c    = rs_bank[xreg_of(fl_reg)][{slot_of(fl_reg), 1'b0}];
        assign fl_v    = rs_bank[xreg_of(fl_reg)][{slot_of(fl_reg), 1'b1}];
    end
endmodule

// File: rtl/ctxsv_outstanding.sv
module ctxsv_outstanding
    import ctxsv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            issue,
    input  logic            retire,
    output logic [CNTW-1:0] cnt,
    output logic            none
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case ({issue, retire})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign none = (cnt == '0);
endmodule

// File: rtl/ctxsv_seq.sv
module ctxsv_seq
    import ctxsv_pkg::*;
#(
    parameter bit SHARED_XBANK = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_save,
    input  logic           start_restore,
    output logic           busy,
    output logic           done,
    output logic [RIW-1:0] rf_rd_addr,
    input  logic [DW-1:0]  rf_rd_data,
    input  logic           rf_rd_carry,
    input  logic           rf_rd_ovf,
    output logic           rf_wr_en,
    output logic [RIW-1:0] rf_wr_addr,
    output logic [DW-1:0]  rf_wr_data,
    output logic           rf_wr_carry,
    output logic           rf_wr_ovf,
    output logic           mem_valid,
    input  logic           mem_ready,
    output logic           mem_we,
    output logic [MAW-1:0] mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_rsp_valid,
    input  logic [DW-1:0]  mem_rdata
);
    phase_e          ph;
    logic [RIW-1:0]  req_idx;
    logic [RIW-1:0]  rsp_idx;
    mreq_t           req;
    logic            req_on;
    logic            issue;
    logic            last_data;
    logic            last_x;
    logic            none_out;
    logic [CNTW-1:0] out_cnt;
    logic [XWW-1:0]  xb_rd_word;
    logic            fl_c;
    logic            fl_v;
    logic            rs_fill;

    assign issue     = req_on & mem_ready;
    assign last_data = (req_idx == RIW'(NREGS - 1));
    assign last_x    = (req_idx == RIW'(NXR - 1));
    assign rs_fill   = (ph == PH_RS_XTRA) || (ph == PH_RS_SYNC);

    always_comb begin
        req    = '0;
        req_on = 1'b0;
        unique case (ph)
            PH_SV_DATA: begin
                req_on    = 1'b1;
                req.we    = 1'b1;
                req.addr  = MAW'(req_idx);
                req.wdata = rf_rd_data;
            end
            PH_SV_XTRA: begin
                req_on    = 1'b1;
                req.we    = 1'b1;
                req.addr  = xaddr(req_idx[XIW-1:0]);
                req.wdata = DW'(xb_rd_word);
            end
            PH_RS_XTRA: begin
                req_on   = 1'b1;
                req.addr = xaddr(req_idx[XIW-1:0]);
            end
            PH_RS_DATA: begin
                req_on   = 1'b1;
                req.addr = MAW'(req_idx);
            end
            default: ;
        endcase
    end

    assign mem_valid  = req_on;
    assign mem_we     = req.we;
    assign mem_addr   = req.addr;
    assign mem_wdata  = req.wdata;
    assign rf_rd_addr = req_idx;
    assign busy       = (ph != PH_IDLE);

    assign rf_wr_en    = mem_rsp_valid && ((ph == PH_RS_DATA) || (ph == PH_RS_DRAIN));
    assign rf_wr_addr  = rsp_idx;
    assign rf_wr_data  = mem_rdata;
    assign rf_wr_carry = fl_c;
    assign rf_wr_ovf   = fl_v;

    ctxsv_outstanding u_out (
        .clk    (clk),
        .rst    (rst),
        .issue  (issue),
        .retire (mem_rsp_valid),
        .cnt    (out_cnt),
        .none   (none_out)
    );

    ctxsv_xbank #(.SHARED(SHARED_XBANK)) u_xbank (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (issue && (ph == PH_SV_DATA)),
        .cap_reg (req_idx),
        .cap_c   (rf_rd_carry),
        .cap_v   (rf_rd_ovf),
        .ld_en   (mem_rsp_valid && rs_fill),
        .ld_idx  (rsp_idx[XIW-1:0]),
        .ld_word (mem_rdata[XWW-1:0]),
        .rd_idx  (req_idx[XIW-1:0]),
        .rd_word (xb_rd_word),
        .fl_reg  (rsp_idx),
        .fl_c    (fl_c),
        .fl_v    (fl_v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            req_idx <= '0;
            rsp_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (mem_rsp_valid) rsp_idx <= rsp_idx + 1'b1;
            unique case (ph)
                PH_IDLE: begin
                    req_idx <= '0;
                    rsp_idx <= '0;
                    if (start_save)         ph <= PH_SV_DATA;
                    else if (start_restore) ph <= PH_RS_XTRA;
                end
                PH_SV_DATA, PH_RS_DATA: begin
                    if (issue) begin
                        req_idx <= last_data ? '0 : req_idx + 1'b1;
                        if (last_data) ph <= (ph == PH_SV_DATA) ? PH_SV_SYNC : PH_RS_DRAIN;
                    end
                end
                PH_SV_XTRA, PH_RS_XTRA: begin
                    if (issue) begin
                        req_idx <= last_x ? '0 : req_idx + 1'b1;
                        if (last_x) ph <= (ph == PH_SV_XTRA) ? PH_SV_DRAIN : PH_RS_SYNC;
                    end
                end
                PH_SV_SYNC: begin
                    if (none_out) ph <= PH_SV_XTRA;
                end
                PH_RS_SYNC: begin
                    if (none_out) begin
                        ph      <= PH_RS_DATA;
                        rsp_idx <= '0;
                    end
                end
                PH_SV_DRAIN, PH_RS_DRAIN: begin
                    if (none_out) begin
                        done <= 1'b1;
                        ph   <= PH_IDLE;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ctxsv_seq_chk.sv
module ctxsv_seq_chk
    import ctxsv_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           busy,
    input logic           done,
    input logic           rf_wr_en,
    input logic           mem_valid,
    input logic           mem_ready,
    input logic           mem_we,
    input logic [MAW-1:0] mem_addr,
    input logic [DW-1:0]  mem_wdata,
    input logic           mem_rsp_valid
);
    logic [CNTW:0] rsp_seen;
    logic [CNTW:0] pending;

    always_ff @(posedge clk) begin
        if (rst || !busy) rsp_seen <= '0;
        else if (mem_rsp_valid) rsp_seen <= rsp_seen + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pending <= '0;
        else pending <= pending + {{CNTW{1'b0}}, (mem_valid && mem_ready)}
                                - {{CNTW{1'b0}}, mem_rsp_valid};
    end

    // R3: extension writes only after every data-write response
    a_r3_sync_before_xwrite: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_we && (mem_addr >= MAW'(NREGS))) |-> (rsp_seen >= (CNTW+1)'(NREGS)));

    // R4: data reads only after all extension-read responses
    a_r4_sync_before_dread: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_we && (mem_addr < MAW'(NREGS))) |-> (rsp_seen >= (CNTW+1)'(NXR)));

    // R5: register writes are driven by restore read responses only
    a_r5_wr_from_rsp: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en |-> (mem_rsp_valid && busy && !(mem_valid && mem_we)));

    // R6: a stalled request is held
    a_r6_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    // R8: done is a single-cycle pulse while idle with nothing outstanding
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && (pending == '0)));
    a_r8_done_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
endmodule

bind ctxsv_seq ctxsv_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .done          (done),
    .rf_wr_en      (rf_wr_en),
    .mem_valid     (mem_valid),
    .mem_ready     (mem_ready),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/ctxsv_seq_tb_top.sv
`timescale 1ns/1ps
module ctxsv_seq_tb_top;
    import ctxsv_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst = 1'b1;
    logic           start_save = 1'b0, start_restore = 1'b0;
    logic           busy, done;
    logic [RIW-1:0] rf_rd_addr, rf_wr_addr;
    logic [DW-1:0]  rf_rd_data, rf_wr_data;
    logic           rf_rd_carry, rf_rd_ovf, rf_wr_en, rf_wr_carry, rf_wr_ovf;
    logic           mem_valid, mem_we;
    logic           mem_ready = 1'b0;
    logic [MAW-1:0] mem_addr;
    logic [DW-1:0]  mem_wdata;
    logic           mem_rsp_valid = 1'b0;
    logic [DW-1:0]  mem_rdata = '0;

    ctxsv_seq dut_i (.*);

    int n_chk = 0, n_err = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // register file model
    logic [DW-1:0] rf_d [NREGS];
    logic          rf_c [NREGS];
    logic          rf_v [NREGS];
    assign rf_rd_data  = rf_d[rf_rd_addr];
    assign rf_rd_carry = rf_c[rf_rd_addr];
    assign rf_rd_ovf   = rf_v[rf_rd_addr];
    always @(posedge clk) if (rf_wr_en) begin
        rf_d[rf_wr_addr] <= rf_wr_data;
        rf_c[rf_wr_addr] <= rf_wr_carry;
        rf_v[rf_wr_addr] <= rf_wr_ovf;
    end

    // memory model
    typedef struct packed { logic [DW-1:0] d; int due; } rsp_t;
    logic [DW-1:0] mem [NREGS+NXR];
    rsp_t rq[$];
    int cyc = 0, lat = 1, rdy_mode = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rsp_valid <= 1'b0;
        if (rq.size() > 0 && rq[0].due <= cyc) begin
            mem_rsp_valid <= 1'b1;
            mem_rdata     <= rq[0].d;
            void'(rq.pop_front());
        end
        if (mem_valid && mem_ready) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            rq.push_back('{(mem_we ? '0 : mem[mem_addr]), cyc + lat});
        end
        case (rdy_mode)
            0:       mem_ready <= 1'b1;
            1:       mem_ready <= ($urandom % 3) != 0;
            default: mem_ready <= cyc[1];
        endcase
    end

    // scoreboard
    mreq_t exp_q[$];
    int rsp_seen = 0, done_cnt = 0, n_acc = 0, n_rsp = 0;
    bit prev_stall = 0, prev_done = 0, first_x = 1, first_d = 1, in_save = 0;
    mreq_t prev_req;
    always @(negedge clk) if (!rst) begin
        if (mem_rsp_valid) begin rsp_seen++; n_rsp++; end
        if (prev_stall)
            chk(mem_valid && {mem_we, mem_addr, mem_wdata} == prev_req, "R6 stalled request held",
                {55'd0, mem_addr}, {55'd0, prev_req.addr});
        if (mem_valid && mem_ready) begin
            n_acc++;
            if (exp_q.size() == 0) begin
                chk(0, "R7 unexpected request", {55'd0, mem_addr}, 64'd0);
            end else begin
                mreq_t e;
                string tg;
                e  = exp_q.pop_front();
                tg = (e.addr >= MAW'(NREGS)) ? (in_save ? "R2 extension write" : "R4 extension read")
                                              : (in_save ? "R1 data write" : "R4 data read");
                chk(mem_we == e.we && mem_addr == e.addr, tg, {54'd0, mem_we, mem_addr}, {54'd0, e.we, e.addr});
                if (e.we) chk(mem_wdata == e.wdata, tg, mem_wdata, e.wdata);
            end
            if (in_save && mem_addr >= MAW'(NREGS) && first_x) begin
                first_x = 0;
                chk(rsp_seen >= NREGS, "R3 sync before extension writes", 64'(rsp_seen), 64'(NREGS));
            end
            if (!in_save && mem_addr < MAW'(NREGS) && first_d) begin
                first_d = 0;
                chk(rsp_seen >= NXR, "R4 sync before data reads", 64'(rsp_seen), 64'(NXR));
            end
        end
        if (done) begin
            done_cnt++;
            chk(!prev_done && !busy, "R8 done single cycle with busy low", {62'd0, prev_done, busy}, 64'd0);
            chk(n_acc == n_rsp && exp_q.size() == 0, "R8 nothing outstanding at done",
                64'(n_acc - n_rsp), 64'd0);
        end
        prev_done  = done;
        prev_stall = mem_valid && !mem_ready;
        prev_req   = '{mem_we, mem_addr, mem_wdata};
    end

    // watchdog
    always @(posedge clk) if (cyc > 150000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    logic [DW-1:0] sv_d [NREGS];
    logic          sv_c [NREGS];
    logic          sv_v [NREGS];

    task automatic wait_done(input bit poke_save, input bit poke_restore);
        int t = 0;
        while (done_cnt == 0) begin
            @(negedge clk);
            t++;
            if (t == 60) begin
                start_save = poke_save; start_restore = poke_restore;
                @(negedge clk);
                start_save = 0; start_restore = 0;
            end
        end
        repeat (30) @(negedge clk);
        chk(done_cnt == 1, "R8 exactly one done", 64'(done_cnt), 64'd1);
        chk(!busy && !mem_valid, "R7 idle after operation", {62'd0, busy, mem_valid}, 64'd0);
    endtask

    task automatic run_save(input int rm, input int lt, input bit poke);
        rdy_mode = rm; lat = lt;
        for (int n = 0; n < NREGS; n++) begin
            exp_q.push_back('{1'b1, MAW'(n), rf_d[n]});
            sv_d[n] = rf_d[n]; sv_c[n] = rf_c[n]; sv_v[n] = rf_v[n];
        end
        for (int k = 0; k < NXR; k++) begin
            logic [DW-1:0] w = '0;
            for (int i = 0; i < BLK; i++) begin
                w[2*i]   = rf_c[k*BLK+i];
                w[2*i+1] = rf_v[k*BLK+i];
            end
            exp_q.push_back('{1'b1, MAW'(NREGS+k), w});
        end
        rsp_seen = 0; done_cnt = 0; first_x = 1; in_save = 1;
        start_save = 1; @(negedge clk); start_save = 0;
        wait_done(1'b1, poke);
    endtask

    task automatic run_restore(input int rm, input int lt, input bit poke);
        int bad = 0;
        rdy_mode = rm; lat = lt;
        for (int k = 0; k < NXR; k++) exp_q.push_back('{1'b0, MAW'(NREGS+k), '0});
        for (int n = 0; n < NREGS; n++) begin
            exp_q.push_back('{1'b0, MAW'(n), '0});
            rf_d[n] = ~sv_d[n]; rf_c[n] = ~sv_c[n]; rf_v[n] = ~sv_v[n];
        end
        rsp_seen = 0; done_cnt = 0; first_d = 1; in_save = 0;
        start_restore = 1; @(negedge clk); start_restore = 0;
        wait_done(poke, 1'b1);
        for (int n = 0; n < NREGS; n++)
            if (rf_d[n] !== sv_d[n] || rf_c[n] !== sv_c[n] || rf_v[n] !== sv_v[n]) bad++;
        chk(bad == 0, "R5 register file restored with flags", 64'(bad), 64'd0);
    endtask

    initial begin
        for (int n = 0; n < NREGS; n++) begin
            rf_d[n] = {$urandom, 24'hA5C3E1, n[7:0]};
            rf_c[n] = n[0];
            rf_v[n] = n[1];
        end
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_valid && !rf_wr_en, "R9 reset state",
            {60'd0, busy, done, mem_valid, rf_wr_en}, 64'd0);
        rst = 0;
        repeat (2) @(negedge clk);
        run_save(0, 1, 1'b0);
        run_restore(1, 3, 1'b0);
        for (int n = 0; n < NREGS; n++) begin
            rf_d[n] = {$urandom, $urandom};
            rf_c[n] = $urandom % 2;
            rf_v[n] = $urandom % 2;
        end
        run_save(2, 4, 1'b1);
        run_restore(1, 2, 1'b1);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule